// File: doc/BRIEF.md
# Sticky diagnostic register bank

This block holds the control and status bytes of a two-channel amplifier controller. It sits behind a byte-level serial slave. The slave gives it a transaction start strobe with a direction flag, then byte handshakes, then a stop strobe. A write transaction loads up to three control bytes in order, and the block decodes them into run, mute and detector-enable outputs and a single-channel mode flag. A read transaction returns three status bytes in order. Per-channel fault pulses, a load-detect pulse and two level inputs (temperature warning and DC load) feed the status bytes.

Fault bits are sticky. The three status bytes are copied into a shadow when a read starts, and the read returns the shadow. A read counts as completed only when all three bytes have been taken and the stop strobe follows. When a read completes, the clearable bits that were reported are cleared and a per-channel read marker is set. Some bits are exempt from this. The load-detect bit stays set until its enable control bit goes low. The two level-driven bits always show the input level. An event that arrives in the same cycle as the clear wins over it.

The transfer state machine has five states. ST_IDLE waits for a start. ST_WR accepts control bytes 0 to 2, and after the third byte it moves to ST_WR_SKIP, which accepts further bytes and drops them. ST_RD offers status bytes 0 to 2, and after the third byte it moves to ST_RD_END, which waits for the stop. Its transitions are as follows. A start moves the machine from any state to ST_WR or ST_RD, depending on the direction flag. A stop moves it from any state to ST_IDLE. Taking the last byte moves ST_WR to ST_WR_SKIP and ST_RD to ST_RD_END. A stop seen in ST_RD_END is the completed-read event.

Top module: `diag_regbank`

## Requirements
- R1: After reset, every control byte is zero: o_active, o_muted, o_ch_run, o_single, o_ac_det_en and o_dc_det_en are all 0. Every status bit is 0, and o_wr_ready and o_rd_valid are low while no transaction is open.
- R2: A write transaction stores its first, second and third data bytes as control bytes 1, 2 and 3. The control bits are: byte 1 bit 0 active, bit 1 DC detect enable, bit 2 AC load-detect enable. Byte 2 bit 0 is mute. In byte 3, bit 1 disables channel 1, bit 2 disables channel 2, and bit 7 selects single-channel mode.
- R3: A write with fewer than three bytes changes only the control bytes it delivered. Bytes after the third are accepted (o_wr_ready high) and have no effect.
- R4: A read returns status byte 1 (channel 1), then status byte 2 (channel 2), then status byte 3 (global). Each byte is taken on o_rd_valid and i_rd_ready. Status byte 3 carries thermal shutdown on bit 0 and undervoltage on bit 1, and bits 7 to 2 read 0.
- R5: The clearable channel bits are bit 6 (short to ground), bit 3 (short to supply), bit 1 (offset) and bit 0 (load short), together with bits 1 and 0 of byte 3. Each sets on a one-cycle pulse of its event input and stays set until a completed read that reported it.
- R6: Bit 5 follows the temperature warning level of the channel, and bit 4 follows its DC load level. A completed read changes neither.
- R7: Bit 2 is set by a completed read. It is cleared by any clearable event of that channel, and an event in the same cycle wins.
- R8: Bit 7 latches the channel's AC load-detect pulse. A completed read leaves it set. It is held at 0, and its pulse is ignored, while control byte 1 bit 2 is 0.
- R9: An event in the same cycle as the completing stop is kept, and the read marker of that channel is left at 0.
- R10: In single-channel mode, channel 2 events and levels are reported in status byte 1, and status byte 2 reads 0. Both o_ch_run bits then follow the channel 1 disable bit.
- R11: o_active is control byte 1 bit 0. o_muted is high only when active and mute are both set. o_ch_run[c] is high when active, not muted and channel c is not disabled.
- R12: A read that ends with a stop before all three bytes were taken clears nothing and sets no marker.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| i_txn_start | input | 1 | Transaction start strobe (also a repeated start) |
| i_txn_rd | input | 1 | Direction when the start strobe is high: 1 read, 0 write |
| i_txn_stop | input | 1 | Transaction stop strobe |
| i_wr_valid | input | 1 | Write byte valid |
| i_wr_data | input | 8 | Write byte |
| o_wr_ready | output | 1 | Write byte accepted |
| o_rd_valid | output | 1 | Read byte available |
| o_rd_data | output | 8 | Read byte |
| i_rd_ready | input | 1 | Read byte taken |
| i_evt_gnd | input | 2 | Short-to-ground pulse per channel |
| i_evt_sup | input | 2 | Short-to-supply pulse per channel |
| i_evt_off | input | 2 | Offset fault pulse per channel |
| i_evt_load | input | 2 | Load short pulse per channel |
| i_evt_ac | input | 2 | AC load-detect pulse per channel |
| i_lvl_warn | input | 2 | Temperature warning level per channel |
| i_lvl_dc | input | 2 | DC load level per channel |
| i_evt_tsd | input | 1 | Thermal shutdown pulse |
| i_evt_uv | input | 1 | Undervoltage pulse |
| o_active | output | 1 | Amplifier out of standby |
| o_muted | output | 1 | Amplifier active and muted |
| o_ch_run | output | 2 | Channel running, per channel |
| o_single | output | 1 | Single-channel mode |
| o_ac_det_en | output | 1 | AC load detection enabled |
| o_dc_det_en | output | 1 | DC detection enabled |

## Verification
The main read-and-clear path is tried with a table of fault patterns: single faults on one channel, faults spread over both channels, global faults only, no fault at all, and every fault at once. Each pattern is read twice. The first read shows that each pulse lands in its own bit position and channel byte, and that the marker of a faulted channel drops. The second read shows that exactly the reported bits cleared and the marker came back. Directed cases keep apart the bits with their own rules. These are the level bits, the load-detect bit with its enable, a read cut short, an event coinciding with the stop, and the single-channel merge. They also cover writes that are shorter or longer than three bytes.

// File: rtl/diag_pkg.sv
package diag_pkg;

    localparam int NCH    = 2;
    localparam int BYTE_W = 8;
    localparam int NBYTES = 3;
    localparam int IDX_W  = $clog2(NBYTES + 1);
    localparam int EV_W   = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR,
        ST_WR_SKIP,
        ST_RD,
        ST_RD_END
    } xfer_st_e;

    // channel status byte bit positions
    localparam int B_AC   = 7;
    localparam int B_GND  = 6;
    localparam int B_WARN = 5;
    localparam int B_DC   = 4;
    localparam int B_SUP  = 3;
    localparam int B_MARK = 2;
    localparam int B_OFF  = 1;
    localparam int B_LOAD = 0;

    localparam logic [BYTE_W-1:0] CLR_MASK =
        BYTE_W'((1 << B_GND) | (1 << B_SUP) | (1 << B_OFF) | (1 << B_LOAD));

    // per-channel event vector fields
    localparam int EV_AC   = 6;
    localparam int EV_GND  = 5;
    localparam int EV_SUP  = 4;
    localparam int EV_OFF  = 3;
    localparam int EV_LOAD = 2;
    localparam int EV_WARN = 1;
    localparam int EV_DC   = 0;

    // control bit positions
    localparam int C1_ACTIVE = 0;
    localparam int C1_DC_EN  = 1;
    localparam int C1_AC_EN  = 2;
    localparam int C2_MUTE   = 0;
    localparam int C3_DIS0   = 1;
    localparam int C3_SINGLE = 7;

    localparam int GLB_W = 2;

endpackage

// File: rtl/diag_xfer_fsm.sv
module diag_xfer_fsm
    import diag_pkg::*;
#(
    parameter int NB = NBYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_start,
    input  logic             i_rd,
    input  logic             i_stop,
    input  logic             i_wr_valid,
    input  logic             i_rd_ready,
    output logic             o_wr_ready,
    output logic             o_rd_valid,
    output logic [IDX_W-1:0] o_idx,
    output logic             o_wr_en,
    output logic             o_snap,
    output logic             o_rd_done
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NB - 1);

    xfer_st_e         state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (i_start) begin
            state_d = i_rd ? ST_RD : ST_WR;
            idx_d   = '0;
        end else if (i_stop) begin
            state_d = ST_IDLE;
            idx_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE:    ;
                ST_WR: begin
                    if (i_wr_valid) begin
                        if (idx_q == LAST) state_d = ST_WR_SKIP;
                        else               idx_d   = idx_q + 1'b1;
                    end
                end
                ST_WR_SKIP: ;
                ST_RD: begin
                    if (i_rd_ready) begin
                        if (idx_q == LAST) state_d = ST_RD_END;
                        else               idx_d   = idx_q + 1'b1;
                    end
                end
                ST_RD_END:  ;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        o_wr_ready = 1'b0;
        o_rd_valid = 1'b0;
        o_wr_en    = 1'b0;
        o_rd_done  = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_WR: begin
                o_wr_ready = 1'b1;
                o_wr_en    = i_wr_valid;
            end
            ST_WR_SKIP: o_wr_ready = 1'b1;
            ST_RD:      o_rd_valid = 1'b1;
            ST_RD_END:  o_rd_done  = i_stop & ~i_start;
            default:    ;
        endcase
        o_snap = i_start & i_rd;
        o_idx  = idx_q;
    end

    // R4
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_rd_valid && i_rd_ready && !i_start && !i_stop && idx_q != LAST)
            |=> (idx_q == $past(idx_q) + 1'b1));

    // R3
    wr_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_wr_en && idx_q == LAST && !i_start && !i_stop)
            |=> (state_q == ST_WR_SKIP && o_wr_ready));

    // R12
    rd_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_rd_done |-> (idx_q == LAST));

endmodule

// File: rtl/diag_ctrl_regs.sv
module diag_ctrl_regs
    import diag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_wr_en,
    input  logic [IDX_W-1:0]  i_idx,
    input  logic [BYTE_W-1:0] i_data,
    output logic              o_active,
    output logic              o_muted,
    output logic [NCH-1:0]    o_ch_run,
    output logic              o_single,
    output logic              o_ac_det_en,
    output logic              o_dc_det_en
);

    logic [BYTE_W-1:0] ctrl_q [NBYTES];

    for (genvar r = 0; r < NBYTES; r++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ctrl_q[r] <= '0;
            else if (i_wr_en && i_idx == IDX_W'(r))
                ctrl_q[r] <= i_data;
        end
    end

    logic run_base;

    always_comb begin
        o_active    = ctrl_q[0][C1_ACTIVE];
        o_dc_det_en = ctrl_q[0][C1_DC_EN];
        o_ac_det_en = ctrl_q[0][C1_AC_EN];
        o_muted     = o_active & ctrl_q[1][C2_MUTE];
        o_single    = ctrl_q[2][C3_SINGLE];
        run_base    = o_active & ~ctrl_q[1][C2_MUTE];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_run
        if (c == 0) begin : g_first
            assign o_ch_run[c] = run_base & ~ctrl_q[2][C3_DIS0];
        end else begin : g_other
            assign o_ch_run[c] = run_base &
                (o_single ? ~ctrl_q[2][C3_DIS0] : ~ctrl_q[2][C3_DIS0 + c]);
        end
    end

    // R2
    wr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (i_wr_en && i_idx == '0) |=> (ctrl_q[0] == $past(i_data)));

    // R3
    wr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !i_wr_en |=> (ctrl_q[2] == $past(ctrl_q[2])));

endmodule

// File: rtl/diag_chan_status.sv
module diag_chan_status
    import diag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EV_W-1:0]   i_evt,
    input  logic              i_ac_en,
    input  logic              i_clr,
    input  logic [BYTE_W-1:0] i_snap,
    output logic [BYTE_W-1:0] o_stat
);

    logic [BYTE_W-1:0] stat_q, stat_d, clr_m, set_v;
    logic              any_evt;

    always_comb begin
        clr_m           = i_clr ? (i_snap & CLR_MASK) : '0;
        set_v           = '0;
        set_v[B_GND]    = i_evt[EV_GND];
        set_v[B_SUP]    = i_evt[EV_SUP];
        set_v[B_OFF]    = i_evt[EV_OFF];
        set_v[B_LOAD]   = i_evt[EV_LOAD];
        any_evt         = |set_v;
        stat_d          = (stat_q & CLR_MASK & ~clr_m) | set_v;
        stat_d[B_AC]    = i_ac_en & (stat_q[B_AC] | i_evt[EV_AC]);
        stat_d[B_WARN]  = i_evt[EV_WARN];
        stat_d[B_DC]    = i_evt[EV_DC];
        stat_d[B_MARK]  = ~any_evt & (i_clr | stat_q[B_MARK]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign o_stat = stat_q;

    // R8
    ac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !i_ac_en |=> !stat_q[B_AC]);

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !i_clr |=> ((stat_q & CLR_MASK & $past(stat_q)) == ($past(stat_q) & CLR_MASK)));

    // R7
    mark_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (i_clr && i_evt[EV_GND:EV_LOAD] == '0) |=> stat_q[B_MARK]);

    // R9
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        i_evt[EV_GND] |=> (stat_q[B_GND] && !stat_q[B_MARK]));

endmodule

// File: rtl/diag_status_bank.sv
module diag_status_bank
    import diag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    i_evt_gnd,
    input  logic [NCH-1:0]    i_evt_sup,
    input  logic [NCH-1:0]    i_evt_off,
    input  logic [NCH-1:0]    i_evt_load,
    input  logic [NCH-1:0]    i_evt_ac,
    input  logic [NCH-1:0]    i_lvl_warn,
    input  logic [NCH-1:0]    i_lvl_dc,
    input  logic              i_evt_tsd,
    input  logic              i_evt_uv,
    input  logic              i_ac_en,
    input  logic              i_single,
    input  logic              i_snap,
    input  logic              i_clr,
    input  logic [IDX_W-1:0]  i_idx,
    output logic [BYTE_W-1:0] o_rd_data
);

    logic [EV_W-1:0]   raw   [NCH];
    logic [EV_W-1:0]   eff   [NCH];
    logic [BYTE_W-1:0] stat  [NCH];
    logic [BYTE_W-1:0] snap_q[NBYTES];
    logic [EV_W-1:0]   merged;
    logic [GLB_W-1:0]  glb_q;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            raw[c] = '0;
            raw[c][EV_AC]   = i_evt_ac[c];
            raw[c][EV_GND]  = i_evt_gnd[c];
            raw[c][EV_SUP]  = i_evt_sup[c];
            raw[c][EV_OFF]  = i_evt_off[c];
            raw[c][EV_LOAD] = i_evt_load[c];
            raw[c][EV_WARN] = i_lvl_warn[c];
            raw[c][EV_DC]   = i_lvl_dc[c];
        end
        merged = '0;
        for (int c = 1; c < NCH; c++) merged = merged | raw[c];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        if (c == 0) begin : g_main
            assign eff[c] = raw[c] | (i_single ? merged : '0);
        end else begin : g_aux
            assign eff[c] = i_single ? '0 : raw[c];
        end

        diag_chan_status i_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .i_evt   (eff[c]),
            .i_ac_en (i_ac_en),
            .i_clr   (i_clr),
            .i_snap  (snap_q[c]),
            .o_stat  (stat[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            glb_q <= '0;
        else
            glb_q <= (glb_q & ~(i_clr ? snap_q[NCH][GLB_W-1:0] : '0)) |
                     {i_evt_uv, i_evt_tsd};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NBYTES; b++) snap_q[b] <= '0;
        end else if (i_snap) begin
            for (int c = 0; c < NCH; c++)
                snap_q[c] <= (c != 0 && i_single) ? '0 : stat[c];
            snap_q[NCH] <= BYTE_W'(glb_q);
        end
    end

    assign o_rd_data = (i_idx < IDX_W'(NBYTES)) ? snap_q[i_idx] : '0;

    // R10
    single_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (i_snap && i_single) |=> (snap_q[1] == '0));

    // R4
    glb_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_q[NCH][BYTE_W-1:GLB_W] == '0);

endmodule

// File: rtl/diag_regbank.sv
module diag_regbank
    import diag_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        i_txn_start,
    input  logic        i_txn_rd,
    input  logic        i_txn_stop,
    input  logic        i_wr_valid,
    input  logic [7:0]  i_wr_data,
    output logic        o_wr_ready,
    output logic        o_rd_valid,
    output logic [7:0]  o_rd_data,
    input  logic        i_rd_ready,
    input  logic [1:0]  i_evt_gnd,
    input  logic [1:0]  i_evt_sup,
    input  logic [1:0]  i_evt_off,
    input  logic [1:0]  i_evt_load,
    input  logic [1:0]  i_evt_ac,
    input  logic [1:0]  i_lvl_warn,
    input  logic [1:0]  i_lvl_dc,
    input  logic        i_evt_tsd,
    input  logic        i_evt_uv,
    output logic        o_active,
    output logic        o_muted,
    output logic [1:0]  o_ch_run,
    output logic        o_single,
    output logic        o_ac_det_en,
    output logic        o_dc_det_en
);

    logic [IDX_W-1:0] idx;
    logic             wr_en, snap, rd_done;

    diag_xfer_fsm #(.NB(NBYTES)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .i_start    (i_txn_start),
        .i_rd       (i_txn_rd),
        .i_stop     (i_txn_stop),
        .i_wr_valid (i_wr_valid),
        .i_rd_ready (i_rd_ready),
        .o_wr_ready (o_wr_ready),
        .o_rd_valid (o_rd_valid),
        .o_idx      (idx),
        .o_wr_en    (wr_en),
        .o_snap     (snap),
        .o_rd_done  (rd_done)
    );

    diag_ctrl_regs i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .i_wr_en     (wr_en),
        .i_idx       (idx),
        .i_data      (i_wr_data),
        .o_active    (o_active),
        .o_muted     (o_muted),
        .o_ch_run    (o_ch_run),
        .o_single    (o_single),
        .o_ac_det_en (o_ac_det_en),
        .o_dc_det_en (o_dc_det_en)
    );

    diag_status_bank i_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .i_evt_gnd  (i_evt_gnd),
        .i_evt_sup  (i_evt_sup),
        .i_evt_off  (i_evt_off),
        .i_evt_load (i_evt_load),
        .i_evt_ac   (i_evt_ac),
        .i_lvl_warn (i_lvl_warn),
        .i_lvl_dc   (i_lvl_dc),
        .i_evt_tsd  (i_evt_tsd),
        .i_evt_uv   (i_evt_uv),
        .i_ac_en    (o_ac_det_en),
        .i_single   (o_single),
        .i_snap     (snap),
        .i_clr      (rd_done),
        .i_idx      (idx),
        .o_rd_data  (o_rd_data)
    );

    // R11
    mute_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_muted |-> (o_active && o_ch_run == '0));

    // R1
    idle_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(i_txn_stop) && !$past(i_txn_start) |-> (!o_wr_ready && !o_rd_valid));

endmodule

// File: tb/test_diag_regbank.sv
module test_diag_regbank;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       i_txn_start = 0, i_txn_rd = 0, i_txn_stop = 0;
    logic       i_wr_valid = 0;
    logic [7:0] i_wr_data = '0;
    logic       o_wr_ready, o_rd_valid;
    logic [7:0] o_rd_data;
    logic       i_rd_ready = 0;
    logic [1:0] i_evt_gnd = '0, i_evt_sup = '0, i_evt_off = '0, i_evt_load = '0;
    logic [1:0] i_evt_ac = '0, i_lvl_warn = '0, i_lvl_dc = '0;
    logic       i_evt_tsd = 0, i_evt_uv = 0;
    logic       o_active, o_muted, o_single, o_ac_det_en, o_dc_det_en;
    logic [1:0] o_ch_run;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    diag_regbank i_diag_regbank (.*);

    // fields: gnd, sup, off, load, {uv,tsd}, byte1, byte2, byte3
    localparam logic [7:0] VEC [0:5][0:7] = '{
        '{8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h40, 8'h04, 8'h00},
        '{8'h00, 8'h02, 8'h02, 8'h00, 8'h00, 8'h04, 8'h0A, 8'h00},
        '{8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h01, 8'h01, 8'h01},
        '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h04, 8'h04, 8'h00},
        '{8'h02, 8'h01, 8'h01, 8'h02, 8'h02, 8'h0A, 8'h41, 8'h02},
        '{8'h03, 8'h03, 8'h03, 8'h03, 8'h03, 8'h4B, 8'h4B, 8'h03}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr_txn(int n, logic [7:0] b0, logic [7:0] b1, logic [7:0] b2,
                          logic [7:0] b3, logic [7:0] b4, output int rdy_cnt);
        logic [7:0] bs [5];
        bs = '{b0, b1, b2, b3, b4};
        rdy_cnt = 0;
        i_txn_start = 1; i_txn_rd = 0;
        tick();
        i_txn_start = 0;
        for (int k = 0; k < n; k++) begin
            i_wr_valid = 1; i_wr_data = bs[k];
            if (o_wr_ready) rdy_cnt++;
            tick();
        end
        i_wr_valid = 0;
        i_txn_stop = 1;
        tick();
        i_txn_stop = 0;
    endtask

    task automatic rd_txn(int n, logic [1:0] gnd_at_stop, output logic [7:0] b [3]);
        b = '{8'hEE, 8'hEE, 8'hEE};
        i_txn_start = 1; i_txn_rd = 1;
        tick();
        i_txn_start = 0;
        for (int k = 0; k < n; k++) begin
            i_rd_ready = 1;
            b[k] = o_rd_valid ? o_rd_data : 8'hEE;
            tick();
        end
        i_rd_ready = 0;
        i_txn_stop = 1;
        i_evt_gnd  = gnd_at_stop;
        tick();
        i_txn_stop = 0;
        i_evt_gnd  = '0;
    endtask

    task automatic chk_rd(string req, logic [7:0] e1, logic [7:0] e2, logic [7:0] e3);
        logic [7:0] b [3];
        rd_txn(3, 2'b00, b);
        chk(req, b[0], e1);
        chk(req, b[1], e2);
        chk(req, b[2], e3);
    endtask

    task automatic chk_out(string req, logic a, logic m, logic [1:0] run, logic s);
        chk(req, {4'h0, a, m, run}, {4'h0, a, m, run} ^ {4'h0, o_active ^ a,
            o_muted ^ m, o_ch_run ^ run});
        chk(req, {7'h0, o_single}, {7'h0, s});
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int         rc;
        logic [7:0] b [3];

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 outputs", {2'b0, o_active, o_muted, o_ch_run, o_single, o_ac_det_en},
            8'h00);
        chk("R1 dc_en", {7'h0, o_dc_det_en}, 8'h00);
        rst_n = 1;
        tick();
        chk("R1 idle handshake", {6'h0, o_wr_ready, o_rd_valid}, 8'h00);
        chk_rd("R1 status zero", 8'h00, 8'h00, 8'h00);

        // R4 R5 R7 table walk: pulse, read, read again
        for (int v = 0; v < 6; v++) begin
            i_evt_gnd  = VEC[v][0][1:0];
            i_evt_sup  = VEC[v][1][1:0];
            i_evt_off  = VEC[v][2][1:0];
            i_evt_load = VEC[v][3][1:0];
            {i_evt_uv, i_evt_tsd} = VEC[v][4][1:0];
            tick();
            i_evt_gnd = '0; i_evt_sup = '0; i_evt_off = '0; i_evt_load = '0;
            i_evt_uv = 0; i_evt_tsd = 0;
            tick();
            chk_rd("R4 R5 capture", VEC[v][5], VEC[v][6], VEC[v][7]);
            chk_rd("R5 R7 cleared", 8'h04, 8'h04, 8'h00);
        end

        // R2 R11 decode
        wr_txn(3, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, rc);
        chk("R2 wr_ready count", 8'(rc), 8'd3);
        chk_out("R2 R11 active", 1, 0, 2'b11, 0);
        wr_txn(3, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, rc);
        chk_out("R11 muted", 1, 1, 2'b00, 0);
        wr_txn(3, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00, rc);
        chk_out("R11 standby", 0, 0, 2'b00, 0);

        // R3 short and long writes
        wr_txn(3, 8'h01, 8'h00, 8'h06, 8'h00, 8'h00, rc);
        chk_out("R2 both disabled", 1, 0, 2'b00, 0);
        wr_txn(2, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00, rc);
        chk_out("R3 two bytes keep byte3", 1, 0, 2'b00, 0);
        chk("R3 dc_en", {7'h0, o_dc_det_en}, 8'h01);
        wr_txn(1, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00, rc);
        chk_out("R3 one byte keep rest", 1, 0, 2'b00, 0);
        chk("R3 ac_en", {6'h0, o_ac_det_en, o_dc_det_en}, 8'h02);
        wr_txn(5, 8'h05, 8'h00, 8'h00, 8'hFF, 8'hFF, rc);
        chk("R3 extra bytes accepted", 8'(rc), 8'd5);
        chk_out("R3 extra bytes dropped", 1, 0, 2'b11, 0);

        // R8 AC load detect, R6 survives read
        i_evt_ac = 2'b01; tick(); i_evt_ac = '0; tick();
        chk_rd("R8 latched", 8'h84, 8'h04, 8'h00);
        chk_rd("R6 R8 kept by read", 8'h84, 8'h04, 8'h00);
        wr_txn(1, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, rc);
        tick();
        chk_rd("R8 cleared by enable low", 8'h04, 8'h04, 8'h00);
        i_evt_ac = 2'b11; tick(); i_evt_ac = '0; tick();
        chk_rd("R8 ignored while disabled", 8'h04, 8'h04, 8'h00);

        // R6 level bits
        i_lvl_warn = 2'b01; i_lvl_dc = 2'b10; tick();
        chk_rd("R6 levels", 8'h24, 8'h14, 8'h00);
        chk_rd("R6 levels kept", 8'h24, 8'h14, 8'h00);
        i_lvl_warn = '0; i_lvl_dc = '0; tick();
        chk_rd("R6 levels follow", 8'h04, 8'h04, 8'h00);

        // R12 incomplete read
        i_evt_gnd = 2'b01; tick(); i_evt_gnd = '0; tick();
        rd_txn(2, 2'b00, b);
        chk("R12 partial byte1", b[0], 8'h40);
        chk("R12 partial byte2", b[1], 8'h04);
        chk_rd("R12 nothing cleared", 8'h40, 8'h04, 8'h00);
        chk_rd("R12 then cleared", 8'h04, 8'h04, 8'h00);

        // R9 event coinciding with completing stop
        rd_txn(3, 2'b10, b);
        chk("R9 snapshot", b[1], 8'h04);
        chk_rd("R9 event kept", 8'h04, 8'h40, 8'h00);
        chk_rd("R9 then cleared", 8'h04, 8'h04, 8'h00);

        // R10 single-channel mode
        wr_txn(3, 8'h01, 8'h00, 8'h80, 8'h00, 8'h00, rc);
        chk_out("R10 single", 1, 0, 2'b11, 1);
        wr_txn(3, 8'h01, 8'h00, 8'h84, 8'h00, 8'h00, rc);
        chk_out("R10 ch2 disable ignored", 1, 0, 2'b11, 1);
        i_evt_gnd = 2'b10; i_evt_sup = 2'b01; tick();
        i_evt_gnd = '0; i_evt_sup = '0; tick();
        chk_rd("R10 merged report", 8'h48, 8'h00, 8'h00);
        wr_txn(3, 8'h01, 8'h00, 8'h82, 8'h00, 8'h00, rc);
        chk_out("R10 ch1 disable governs", 1, 0, 2'b00, 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule